// File: doc/BRIEF.md
# Alert Response Address Responder

This block lets a device that has something to report pull a shared, active-low alert line and then identify itself to the bus master. Any of its alert-cause inputs (for example an out-of-range reading or a disconnected sensor) sets an internal alert flag, and the block pulls the open-drain alert line low. The master then reads from the reserved alert response address. Every alerting device acknowledges that read and returns its own 7-bit address with a 1 in the least significant position.

When several devices are alerting at once, they all drive their reply onto the wired-AND data line. Each responder watches the line while it sends. A responder that leaves the line high but sees it pulled low has lost to a device with a lower address. It stops driving and keeps its alert asserted, so the master repeats the read until every device has answered.

The alert flag is cleared only after a complete, unchallenged reply, and only if no cause is active in that same cycle. Both bus lines are oversampled with the block's own clock. General register access and the limit comparisons that produce the alert causes are handled elsewhere.

Top module: `smba_responder`

## Requirements
- R1: While reset is asserted, `sda_oe` and `alert_oe` are both 0, even if alert causes are present.
- R2: If any bit of `cond_i` is 1 at a clock edge, `alert_oe` is 1 after that edge.
- R3: Once set, `alert_oe` stays 1 after every cause has dropped, until the block completes a reply.
- R4: A header byte of 0x19 (the response address 0001100 followed by a read bit of 1), received while `alert_oe` is 1, is acknowledged: SDA is held low for the ninth SCL pulse.
- R5: Any other header byte, including the response address with a write bit (0x18) and this device's own address, gets no acknowledge, and `sda_oe` stays 0 until the next start or stop.
- R6: While `alert_oe` is 0, a 0x19 header is not acknowledged and nothing is driven.
- R7: After the acknowledge, the block sends the byte {DEV_ADDR, 1} most significant bit first, with one bit per SCL pulse. With the default DEV_ADDR of 0x2A this byte is 0x55. SDA does not change while SCL is high.
- R8: If the block leaves SDA released for a 1 bit and sees SDA low while SCL is high, it stops driving for the rest of the transfer and keeps `alert_oe` at 1.
- R9: After all eight reply bits are sent without loss, `alert_oe` drops to 0 if no cause is active.
- R10: If a cause is active in the cycle the reply completes, `alert_oe` stays 1.
- R11: After a stop, a new response-address read is recognised again.
- R12: A start condition in the middle of a header restarts header reception from the first bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock, which oversamples the bus |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| cond_i | input | NUM_COND | Alert-cause flags, active high |
| scl_i | input | 1 | Sampled level of the bus clock line |
| sda_i | input | 1 | Sampled level of the bus data line |
| sda_oe | output | 1 | 1 pulls the data line low |
| alert_oe | output | 1 | 1 pulls the shared alert line low |

## Verification
Two things can land in the same cycle: the clear request that a finished reply produces, and a cause flag that sets the alert. The bench provokes this by holding a cause high through an entire response read. It then judges the result at the alert output after the stop, where the line must still be pulled low. A further read with the cause gone must release the line. The second overlap is between the reply bits and a competing device on the wired-AND line. The bench models the competitor as a lower-addressed device driving its own reply. The byte the master reads must match the competitor's byte exactly, which shows that the block stopped driving at the first bit where the two replies differ.

// File: rtl/smba_pkg.sv
package smba_pkg;

  // Reserved 7-bit address every alerting device answers to.
  localparam logic [6:0] ARA_ADDR = 7'b0001100;
  localparam int         BYTE_W   = 8;

  typedef enum logic [2:0] {
    SMB_IDLE,   // waiting for a start condition
    SMB_RXHDR,  // shifting in the header byte
    SMB_ACK,    // driving the acknowledge bit
    SMB_TX,     // sending the reply byte
    SMB_SKIP    // not addressed, finished or lost; wait for start/stop
  } smb_state_e;

endpackage

// File: rtl/smba_bus_sync.sv
module smba_bus_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_s,
  output logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det
);

  logic [STAGES-1:0] scl_sh_q;
  logic [STAGES-1:0] sda_sh_q;
  logic              scl_prev_q;
  logic              sda_prev_q;

  // The idle bus is high, so every stage resets to 1.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_sh_q   <= '1;
      sda_sh_q   <= '1;
      scl_prev_q <= 1'b1;
      sda_prev_q <= 1'b1;
    end else begin
      scl_sh_q   <= {scl_sh_q[STAGES-2:0], scl_i};
      sda_sh_q   <= {sda_sh_q[STAGES-2:0], sda_i};
      scl_prev_q <= scl_sh_q[STAGES-1];
      sda_prev_q <= sda_sh_q[STAGES-1];
    end
  end

  assign scl_s     = scl_sh_q[STAGES-1];
  assign sda_s     = sda_sh_q[STAGES-1];
  assign scl_rise  =  scl_s & ~scl_prev_q;
  assign scl_fall  = ~scl_s &  scl_prev_q;
  // A data edge while the clock stays high is a bus condition.
  assign start_det =  scl_s & scl_prev_q &  sda_prev_q & ~sda_s;
  assign stop_det  =  scl_s & scl_prev_q & ~sda_prev_q &  sda_s;

endmodule

// File: rtl/smba_alert_latch.sv
module smba_alert_latch #(
  parameter int NUM_COND = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [NUM_COND-1:0] cond_i,
  input  logic                clear_i,
  output logic                alert_o
);

  logic alert_q;
  logic alert_d;

  // Set beats clear: a cause present in the clear cycle keeps the flag.
  always_comb begin
    alert_d = (|cond_i) | (alert_q & ~clear_i);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) alert_q <= 1'b0;
    else        alert_q <= alert_d;
  end

  assign alert_o = alert_q;

endmodule

// File: rtl/smba_ara_engine.sv
module smba_ara_engine
  import smba_pkg::*;
#(
  parameter logic [6:0] DEV_ADDR = 7'h2A
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_s,
  input  logic sda_s,
  input  logic scl_rise,
  input  logic scl_fall,
  input  logic start_det,
  input  logic stop_det,
  input  logic alert_i,
  output logic sda_oe,
  output logic won_o
);

  localparam int                 CNT_W   = $clog2(BYTE_W);
  localparam logic [CNT_W-1:0]   LAST    = CNT_W'(BYTE_W - 1);
  localparam logic [BYTE_W-1:0]  HDR_RD  = {ARA_ADDR, 1'b1};
  localparam logic [BYTE_W-1:0]  REPLY   = {DEV_ADDR, 1'b1};

  smb_state_e         state_q, state_d;
  logic [CNT_W-1:0]   cnt_q,   cnt_d;
  logic [BYTE_W-1:0]  sh_q,    sh_d;
  logic               oe_q,    oe_d;
  logic               won_q,   won_d;
  logic [BYTE_W-1:0]  hdr_next;

  assign hdr_next = {sh_q[BYTE_W-2:0], sda_s};

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    sh_d    = sh_q;
    oe_d    = oe_q;
    won_d   = 1'b0;

    if (start_det) begin
      state_d = SMB_RXHDR;
      cnt_d   = '0;
      oe_d    = 1'b0;
    end else if (stop_det) begin
      state_d = SMB_IDLE;
      oe_d    = 1'b0;
    end else begin
      unique case (state_q)
        SMB_IDLE: ;
        SMB_RXHDR: begin
          if (scl_rise) begin
            sh_d = hdr_next;
            if (cnt_q == LAST) begin
              cnt_d   = '0;
              state_d = (alert_i && hdr_next == HDR_RD) ? SMB_ACK : SMB_SKIP;
            end else begin
              cnt_d = cnt_q + 1'b1;
            end
          end
        end
        SMB_ACK: begin
          // First falling edge starts the acknowledge; the second ends it.
          if (scl_fall) begin
            if (!oe_q) begin
              oe_d = 1'b1;
            end else begin
              state_d = SMB_TX;
              cnt_d   = '0;
              sh_d    = REPLY;
              oe_d    = ~REPLY[BYTE_W-1];
            end
          end
        end
        SMB_TX: begin
          if (scl_s && !oe_q && !sda_s) begin
            // Line released by this block but held low by another device.
            state_d = SMB_SKIP;
          end else if (scl_fall) begin
            if (cnt_q == LAST) begin
              oe_d    = 1'b0;
              won_d   = 1'b1;
              state_d = SMB_SKIP;
            end else begin
              cnt_d = cnt_q + 1'b1;
              sh_d  = {sh_q[BYTE_W-2:0], 1'b1};
              oe_d  = ~sh_q[BYTE_W-2];
            end
          end
        end
        SMB_SKIP: ;
        default: state_d = SMB_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= SMB_IDLE;
      cnt_q   <= '0;
      sh_q    <= '0;
      oe_q    <= 1'b0;
      won_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      sh_q    <= sh_d;
      oe_q    <= oe_d;
      won_q   <= won_d;
    end
  end

  assign sda_oe = oe_q;
  assign won_o  = won_q;

endmodule

// File: rtl/smba_responder.sv
module smba_responder #(
  parameter logic [6:0] DEV_ADDR    = 7'h2A,
  parameter int         NUM_COND    = 2,
  parameter int         SYNC_STAGES = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [NUM_COND-1:0] cond_i,
  input  logic                scl_i,
  input  logic                sda_i,
  output logic                sda_oe,
  output logic                alert_oe
);

  logic [1:0] rst_pipe_q;
  logic       rst_core_n;
  logic       scl_s, sda_s, scl_rise, scl_fall, start_det, stop_det;
  logic       alert, won;

  // Reset asserts at once and is released on a clock edge.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe_q <= 2'b00;
    else        rst_pipe_q <= {rst_pipe_q[0], 1'b1};
  end
  assign rst_core_n = rst_pipe_q[1];

  smba_bus_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_core_n), .scl_i(scl_i), .sda_i(sda_i),
    .scl_s(scl_s), .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_det(start_det), .stop_det(stop_det)
  );

  smba_alert_latch #(.NUM_COND(NUM_COND)) u_latch (
    .clk(clk), .rst_n(rst_core_n), .cond_i(cond_i), .clear_i(won),
    .alert_o(alert)
  );

  smba_ara_engine #(.DEV_ADDR(DEV_ADDR)) u_engine (
    .clk(clk), .rst_n(rst_core_n), .scl_s(scl_s), .sda_s(sda_s),
    .scl_rise(scl_rise), .scl_fall(scl_fall), .start_det(start_det),
    .stop_det(stop_det), .alert_i(alert), .sda_oe(sda_oe), .won_o(won)
  );

  assign alert_oe = alert;

endmodule

// File: rtl/smba_responder_chk.sv
module smba_responder_chk #(
  parameter int NUM_COND = 2
) (
  input logic                clk,
  input logic                rst_n,
  input logic [NUM_COND-1:0] cond_i,
  input logic                alert_oe,
  input logic                sda_oe,
  input logic                won,
  input logic                scl_s,
  input logic                start_det,
  input logic                stop_det
);

  // R2
  alert_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|cond_i) |=> alert_oe);

  // R3
  alert_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (alert_oe && !won) |=> alert_oe);

  // R3
  alert_fall_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(alert_oe) |-> $past(won));

  // R6
  drive_needs_alert_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sda_oe |-> alert_oe);

  // R7
  sda_stable_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (scl_s && $past(scl_s) && !$past(start_det) && !$past(stop_det))
      |-> $stable(sda_oe));

  // R9
  release_after_win_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (won && !(|cond_i)) |=> !alert_oe);

  // R10
  cause_keeps_alert_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (won && (|cond_i)) |=> alert_oe);

endmodule

bind smba_responder smba_responder_chk #(.NUM_COND(NUM_COND)) u_chk (
  .clk(clk), .rst_n(rst_core_n), .cond_i(cond_i), .alert_oe(alert_oe),
  .sda_oe(sda_oe), .won(won), .scl_s(scl_s), .start_det(start_det),
  .stop_det(stop_det)
);

// File: tb/smba_responder_tb.sv
module smba_responder_tb;

  localparam logic [6:0] DEV   = 7'h2A;
  localparam logic [7:0] REPLY = {DEV, 1'b1};      // 0x55
  localparam logic [7:0] RIVAL = {7'h29, 1'b1};    // 0x53, lower address
  localparam int         H     = 8;                // clocks per bus half period

  // Vector: [13] pulse a cause, [12] which cause, [11:10] causes held
  // through the read, [9:2] header byte, [1] ack expected, [0] alert after.
  localparam int NV = 7;
  localparam logic [13:0] VEC [NV] = '{
    {1'b1, 1'b0, 2'b00, 8'h19, 1'b1, 1'b0},
    {1'b0, 1'b0, 2'b00, 8'h19, 1'b0, 1'b0},
    {1'b1, 1'b1, 2'b00, 8'h18, 1'b0, 1'b1},
    {1'b0, 1'b0, 2'b00, 8'h54, 1'b0, 1'b1},
    {1'b0, 1'b0, 2'b00, 8'h19, 1'b1, 1'b0},
    {1'b1, 1'b0, 2'b01, 8'h19, 1'b1, 1'b1},
    {1'b0, 1'b0, 2'b00, 8'h19, 1'b1, 1'b0}
  };

  logic       clk = 1'b0;
  logic       rst_n;
  logic [1:0] cond;
  logic       scl, sda_m, comp;
  logic       sda_oe, alert_oe;
  wire        sda_bus = sda_m & ~sda_oe & ~comp;

  int errors = 0;
  int checks = 0;
  bit done   = 1'b0;

  always #5 clk = ~clk;

  smba_responder #(.DEV_ADDR(DEV), .NUM_COND(2), .SYNC_STAGES(2)) u_dut (
    .clk(clk), .rst_n(rst_n), .cond_i(cond), .scl_i(scl), .sda_i(sda_bus),
    .sda_oe(sda_oe), .alert_oe(alert_oe)
  );

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic hp();
    repeat (H) @(negedge clk);
  endtask

  task automatic bstart();
    sda_m = 1'b1; hp(); scl = 1'b1; hp(); sda_m = 1'b0; hp(); scl = 1'b0;
  endtask

  task automatic bstop();
    sda_m = 1'b0; comp = 1'b0; hp(); scl = 1'b1; hp(); sda_m = 1'b1; hp();
  endtask

  task automatic wbit(input logic b);
    sda_m = b; comp = 1'b0; hp(); scl = 1'b1; hp(); scl = 1'b0;
  endtask

  task automatic rbit(input logic pull, output logic v);
    sda_m = 1'b1; comp = pull; hp(); scl = 1'b1;
    repeat (H/2) @(negedge clk);
    v = sda_bus;
    repeat (H/2) @(negedge clk);
    scl = 1'b0;
  endtask

  task automatic xfer(input logic [7:0] hdr, input logic [7:0] rival,
                      input logic rival_ack, input logic junk,
                      output logic ack, output logic [7:0] rd);
    logic v;
    bstart();
    if (junk) begin
      wbit(1'b1); wbit(1'b0); wbit(1'b1);
      bstart();                          // repeated start mid-header
    end
    for (int i = 7; i >= 0; i--) wbit(hdr[i]);
    rbit(rival_ack, v);
    ack = ~v;
    for (int i = 7; i >= 0; i--) begin
      rbit(~rival[i], v);
      rd[i] = v;
    end
    wbit(1'b1);                          // master NACK
    bstop();
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic       ack;
    logic [7:0] rd;
    logic       model;
    logic [13:0] v;
    rst_n = 1'b0; cond = 2'b11; scl = 1'b1; sda_m = 1'b1; comp = 1'b0;
    repeat (4) @(negedge clk);
    check("R1 alert in reset", {7'd0, alert_oe}, 8'd0);
    check("R1 sda in reset", {7'd0, sda_oe}, 8'd0);
    cond = 2'b00;
    @(negedge clk); rst_n = 1'b1;
    repeat (6) @(negedge clk);
    model = 1'b0;

    for (int i = 0; i < NV; i++) begin
      v = VEC[i];
      if (v[13]) begin
        cond[v[12]] = 1'b1;
        @(negedge clk);
        check("R2 set latency", {7'd0, alert_oe}, 8'd1);
        cond = 2'b00;
        model = 1'b1;
      end
      repeat (4) @(negedge clk);
      check("R3 alert held", {7'd0, alert_oe}, {7'd0, model});
      cond = v[11:10];
      xfer(v[9:2], 8'hFF, 1'b0, 1'b0, ack, rd);
      if (v[1]) begin
        check("R4 ack", {7'd0, ack}, 8'd1);
        check("R7 reply byte", rd, REPLY);
      end else begin
        check(model ? "R5 no ack" : "R6 no ack", {7'd0, ack}, 8'd0);
        check("R5 not driven", rd, 8'hFF);
      end
      cond = 2'b00;
      repeat (3) @(negedge clk);
      check(v[11:10] != 2'b00 ? "R10 cause kept" : "R9 alert after",
            {7'd0, alert_oe}, {7'd0, v[0]});
      model = v[0];
    end

    // R8: lower-addressed rival wins arbitration.
    cond = 2'b10; @(negedge clk); cond = 2'b00;
    xfer(8'h19, RIVAL, 1'b1, 1'b0, ack, rd);
    check("R8 ack", {7'd0, ack}, 8'd1);
    check("R8 bus byte", rd, RIVAL);
    repeat (3) @(negedge clk);
    check("R8 alert kept", {7'd0, alert_oe}, 8'd1);

    // R11: repeated read after a stop, now unopposed.
    xfer(8'h19, 8'hFF, 1'b0, 1'b0, ack, rd);
    check("R11 ack", {7'd0, ack}, 8'd1);
    check("R11 reply", rd, REPLY);
    repeat (3) @(negedge clk);
    check("R11 released", {7'd0, alert_oe}, 8'd0);

    // R12: start in the middle of a header restarts reception.
    cond = 2'b01; @(negedge clk); cond = 2'b00;
    xfer(8'h19, 8'hFF, 1'b0, 1'b1, ack, rd);
    check("R12 ack", {7'd0, ack}, 8'd1);
    check("R12 reply", rd, REPLY);
    repeat (3) @(negedge clk);
    check("R12 released", {7'd0, alert_oe}, 8'd0);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule